// File: doc/BRIEF.md
# Bit-Serial Borrow-Save to Binary Final Converter

This block turns a result held as a borrow-save pair (a plus word and a minus word whose difference is the value S) into plain binary, one bit per clock, least significant bit first. Two serial adders run side by side: the first forms S = P − N as a W-bit two's-complement stream, and the second adds the modulus m to that stream on the fly, giving S + m. Both candidate streams leave the block together. Choosing between them is left to the logic around it. One cycle after the last bit, the block reports the sign of S, so the receiver can take S + m when S is negative. The value is assumed to satisfy −m < S < m, so one of the two streams always lies in the range 0 ≤ value < m.

The plus word, the minus word and the modulus are loaded in parallel by a load pulse. While the bits leave at the low end of the operand registers, a new operand enters bit-serially at the high end of the plus register, and zeros enter the minus register. The modulus register rotates, so after a full pass it again holds m. A rerun pulse then converts the operand that was shifted in, with a zero minus word and the same modulus, and no parallel load is needed.

Top module: `bs_serial_converter`

## Requirements
- R1: After reset, `valid_o`, `frame_o` and `sign_valid_o` are low and stay low until a pass is started.
- R2: A pass lasts exactly W cycles, beginning in the cycle after the start edge. `valid_o` is high in every one of those cycles, and `frame_o` is high only in the first of them.
- R3: In pass cycle j (counting from 0), `diff_o` carries bit j of (P − N) mod 2^W.
- R4: In pass cycle j, `summ_o` carries bit j of (P − N + m) mod 2^W.
- R5: In the cycle after the last bit, `sign_valid_o` is high for one cycle and `valid_o` is low. `sign_o` is then 1 exactly when P < N, that is, when S is negative.
- R6: The bit on `ser_i` that is sampled at the clock edge ending pass cycle j becomes bit j of the next operand. A `rerun_i` pulse while idle starts a pass on that operand, with minus word 0 and the modulus of the previous pass.
- R7: A `rerun_i` pulse during a pass is ignored. The current stream goes on unchanged, and no new frame starts.
- R8: A `load_i` pulse during a pass drops that pass and starts a new one on the new words. No sign report is given for the dropped pass.
- R9: The borrow of the first adder and the carry of the second adder are cleared at every start. A pass that follows one that ended with a borrow or a carry out is still exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Parallel load of the three words and start of a pass |
| rerun_i | input | 1 | Start a pass on the operand shifted in (used only when idle) |
| pos_i | input | W | Plus word P of the borrow-save pair |
| neg_i | input | W | Minus word N of the borrow-save pair |
| mod_i | input | W | Modulus m |
| ser_i | input | 1 | Serial input of the next operand, least significant bit first |
| valid_o | output | 1 | A stream bit is present |
| frame_o | output | 1 | Marks the first (least significant) bit of a pass |
| diff_o | output | 1 | Serial bit of S = P − N |
| summ_o | output | 1 | Serial bit of S + m |
| sign_valid_o | output | 1 | Sign report strobe, one cycle after the last bit |
| sign_o | output | 1 | 1 when S is negative |

## Verification
The assertions take for granted that the load and rerun pulses are single-cycle, synchronous controls. They also assume the parallel words respect −m < P − N < m, because the usefulness of the sign report rests on that range. The stimulus draws the modulus first, then draws S inside that open interval, then draws a minus word that keeps both words within W bits. Operands that are shifted in are drawn below m, so reruns also stay in range. Interrupted passes are followed by full passes, so every stream that is checked starts from a clean start.

// File: rtl/bs_conv_pkg.sv
package bs_conv_pkg;

  // One step of a serial subtractor: returns {borrow_out, diff}
  function automatic logic [1:0] sub_step(input logic p, input logic n, input logic b);
    logic d;
    logic bo;
    d  = p ^ n ^ b;
    bo = (~p & n) | (~(p ^ n) & b);
    return {bo, d};
  endfunction

  // One step of a serial adder: returns {carry_out, sum}
  function automatic logic [1:0] add_step(input logic a, input logic b, input logic c);
    logic s;
    logic co;
    s  = a ^ b ^ c;
    co = (a & b) | (a & c) | (b & c);
    return {co, s};
  endfunction

endpackage

// File: rtl/bs_conv_seq.sv
module bs_conv_seq #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic rerun_i,
  output logic start_o,
  output logic step_o,
  output logic busy_o,
  output logic first_o,
  output logic last_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign start_o = load_i | (rerun_i & ~busy_q);
  assign step_o  = busy_q & ~start_o;
  assign busy_o  = busy_q;
  assign first_o = busy_q & (cnt_q == '0);
  assign last_o  = step_o & (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST_IDX) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bs_conv_shift.sv
module bs_conv_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         ser_i,
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] neg_i,
  input  logic [W-1:0] mod_i,
  output logic         p_lsb_o,
  output logic         n_lsb_o,
  output logic         m_lsb_o
);
  logic [W-1:0] pos_q;
  logic [W-1:0] neg_q;
  logic [W-1:0] mod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      neg_q <= '0;
      mod_q <= '0;
    end else if (load_i) begin
      pos_q <= pos_i;
      neg_q <= neg_i;
      mod_q <= mod_i;
    end else if (step_i) begin
      pos_q <= {ser_i, pos_q[W-1:1]};
      neg_q <= {1'b0, neg_q[W-1:1]};
      mod_q <= {mod_q[0], mod_q[W-1:1]};
    end
  end

  assign p_lsb_o = pos_q[0];
  assign n_lsb_o = neg_q[0];
  assign m_lsb_o = mod_q[0];
endmodule

// File: rtl/bs_conv_sub.sv
module bs_conv_sub (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  input  logic p_i,
  input  logic n_i,
  output logic d_o,
  output logic borrow_next_o
);
  import bs_conv_pkg::*;

  logic       brw_q;
  logic [1:0] res;

  assign res           = sub_step(p_i, n_i, brw_q);
  assign d_o           = res[0];
  assign borrow_next_o = res[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      brw_q <= 1'b0;
    else if (clr_i)  brw_q <= 1'b0;
    else if (step_i) brw_q <= res[1];
  end
endmodule

// File: rtl/bs_conv_addm.sv
module bs_conv_addm (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  input  logic d_i,
  input  logic m_i,
  output logic s_o
);
  import bs_conv_pkg::*;

  logic       cry_q;
  logic [1:0] res;

  assign res = add_step(d_i, m_i, cry_q);
  assign s_o = res[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cry_q <= 1'b0;
    else if (clr_i)  cry_q <= 1'b0;
    else if (step_i) cry_q <= res[1];
  end
endmodule

// File: rtl/bs_serial_converter.sv
module bs_serial_converter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         rerun_i,
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] neg_i,
  input  logic [W-1:0] mod_i,
  input  logic         ser_i,
  output logic         valid_o,
  output logic         frame_o,
  output logic         diff_o,
  output logic         summ_o,
  output logic         sign_valid_o,
  output logic         sign_o
);
  // named internal events
  logic start_w;
  logic step_w;
  logic busy_w;
  logic first_w;
  logic last_w;
  logic p_lsb_w;
  logic n_lsb_w;
  logic m_lsb_w;
  logic d_w;
  logic s_w;
  logic brw_next_w;
  logic sgn_vld_q;
  logic sgn_q;

  bs_conv_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .rerun_i(rerun_i),
    .start_o(start_w), .step_o(step_w), .busy_o(busy_w),
    .first_o(first_w), .last_o(last_w)
  );

  bs_conv_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_w), .ser_i(ser_i),
    .pos_i(pos_i), .neg_i(neg_i), .mod_i(mod_i),
    .p_lsb_o(p_lsb_w), .n_lsb_o(n_lsb_w), .m_lsb_o(m_lsb_w)
  );

  bs_conv_sub u_sub (
    .clk(clk), .rst_n(rst_n), .clr_i(start_w), .step_i(step_w),
    .p_i(p_lsb_w), .n_i(n_lsb_w), .d_o(d_w), .borrow_next_o(brw_next_w)
  );

  bs_conv_addm u_add (
    .clk(clk), .rst_n(rst_n), .clr_i(start_w), .step_i(step_w),
    .d_i(d_w), .m_i(m_lsb_w), .s_o(s_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn_vld_q <= 1'b0;
      sgn_q     <= 1'b0;
    end else begin
      sgn_vld_q <= last_w;
      if (last_w) sgn_q <= brw_next_w;
    end
  end

  assign valid_o      = busy_w;
  assign frame_o      = first_w;
  assign diff_o       = d_w;
  assign summ_o       = s_w;
  assign sign_valid_o = sgn_vld_q;
  assign sign_o       = sgn_q;
endmodule

// File: rtl/bs_serial_converter_chk.sv
module bs_serial_converter_chk #(
  parameter int W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic load_i,
  input logic valid_o,
  input logic frame_o,
  input logic sign_valid_o
);
  localparam int LW = $clog2(W + 1) + 1;
  logic [LW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (frame_o) run_len <= LW'(1);
    else if (valid_o) run_len <= run_len + 1'b1;
  end

  AST_LOAD_FRAMES: assert property (@(posedge clk) disable iff (!rst_n) load_i |=> frame_o); // R8
  AST_FRAME_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n) frame_o |-> valid_o); // R2
  AST_NO_REFRAME: assert property (@(posedge clk) disable iff (!rst_n) (valid_o && !load_i) |=> !frame_o); // R7
  AST_SIGN_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n) sign_valid_o |-> (!valid_o && $past(valid_o))); // R5
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) sign_valid_o |-> (run_len == LW'(W))); // R2
  AST_SIGN_PULSE: assert property (@(posedge clk) disable iff (!rst_n) sign_valid_o |=> !sign_valid_o); // R5
endmodule

bind bs_serial_converter bs_serial_converter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .valid_o(valid_o),
  .frame_o(frame_o), .sign_valid_o(sign_valid_o)
);

// File: tb/bs_serial_converter_tb.sv
`timescale 1ns/1ps
module bs_serial_converter_tb;
  localparam int W = 16;
  localparam longint MASK = (longint'(1) << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic         rerun_i = 1'b0;
  logic [W-1:0] pos_i = '0;
  logic [W-1:0] neg_i = '0;
  logic [W-1:0] mod_i = '0;
  logic         ser_i = 1'b0;
  logic valid_o, frame_o, diff_o, summ_o, sign_valid_o, sign_o;

  int vectors = 0;
  int miscompares = 0;
  longint cur_m = 0;

  always #10 clk = ~clk;

  bs_serial_converter #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .rerun_i(rerun_i),
    .pos_i(pos_i), .neg_i(neg_i), .mod_i(mod_i), .ser_i(ser_i),
    .valid_o(valid_o), .frame_o(frame_o), .diff_o(diff_o), .summ_o(summ_o),
    .sign_valid_o(sign_valid_o), .sign_o(sign_o)
  );

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  // at a negedge: pulse load for one edge, return at the next negedge
  task automatic do_load(input longint p, input longint n, input longint m);
    load_i = 1'b1;
    pos_i = W'(p); neg_i = W'(n); mod_i = W'(m);
    cur_m = m;
    @(posedge clk); @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_rerun();
    rerun_i = 1'b1;
    @(posedge clk); @(negedge clk);
    rerun_i = 1'b0;
  endtask

  // checks nbits of a pass on operand (p,n); feeds nxt serially; pulses rerun at cycle rr
  task automatic stream(input longint p, input longint n, input longint nxt,
                        input int nbits, input int rr);
    longint s, dv, sv;
    s  = p - n;
    dv = s & MASK;
    sv = (s + cur_m) & MASK;
    for (int j = 0; j < nbits; j++) begin
      chk("R2", "valid", valid_o, 1);
      chk("R2", "frame", frame_o, (j == 0) ? 1 : 0);
      chk("R3", "diff bit", diff_o, (dv >> j) & 1);
      chk("R4", "sum bit", summ_o, (sv >> j) & 1);
      chk("R5", "no early sign", sign_valid_o, 0);
      ser_i = 1'((nxt >> j) & 1);
      rerun_i = (j == rr);
      @(posedge clk); @(negedge clk);
      rerun_i = 1'b0;
    end
    if (nbits == W) begin
      chk("R5", "valid off", valid_o, 0);
      chk("R5", "sign strobe", sign_valid_o, 1);
      chk("R5", "sign", sign_o, (s < 0) ? 1 : 0);
      chk("R7", "no restart", frame_o, 0);
    end
  endtask

  task automatic pick(output longint p, output longint n, output longint m);
    longint s, lo, hi;
    m = (longint'($urandom) % (MASK - 3)) + 3;
    m = m | 1;
    if (m > MASK) m = MASK;
    s = (longint'($urandom) % (2 * m - 1)) - (m - 1);
    lo = (s < 0) ? -s : 0;
    hi = (s < 0) ? MASK : MASK - s;
    n = lo + (longint'($urandom) % (hi - lo + 1));
    p = n + s;
  endtask

  initial begin
    longint p, n, m, nx;
    @(negedge clk);
    chk("R1", "valid in reset", valid_o, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "valid idle", valid_o, 0);
      chk("R1", "frame idle", frame_o, 0);
      chk("R1", "sign strobe idle", sign_valid_o, 0);
    end

    // directed corners: S=0, S=-1, S=m-1, S=-(m-1), small and large m
    do_load(1234, 1234, 4097);        stream(1234, 1234, 0, W, -1);
    @(negedge clk); chk("R5", "strobe one cycle", sign_valid_o, 0);
    do_load(0, 1, 4097);              stream(0, 1, 0, W, -1);
    do_load(2, 0, 3);                 stream(2, 0, 0, W, -1);
    do_load(0, 2, 3);                 stream(0, 2, 0, W, -1);
    do_load(MASK - 1, 0, MASK);       stream(MASK - 1, 0, 0, W, -1);
    // R9: previous pass ended with borrow and carry set
    do_load(0, MASK - 1, MASK);       stream(0, MASK - 1, 0, W, -1);
    do_load(5, 3, 11);                stream(5, 3, 0, W, -1);

    // R6: shift in an operand, then rerun on it
    nx = 4000;
    do_load(100, 300, 4001);          stream(100, 300, nx, W, -1);
    do_rerun();                       stream(nx, 0, 77, W, -1);
    do_rerun();                       stream(77, 0, 0, W, -1);

    // R7: rerun pulsed mid-pass is ignored
    do_load(900, 50, 2049);           stream(900, 50, 0, W, 4);

    // R8: load during a pass restarts on new words
    do_load(10, 700, 1025);           stream(10, 700, 0, 6, -1);
    do_load(600, 20, 1025);           stream(600, 20, 0, W, -1);

    // random passes, with reruns on shifted-in operands
    for (int t = 0; t < 60; t++) begin
      pick(p, n, m);
      nx = longint'($urandom) % m;
      do_load(p, n, m);
      stream(p, n, nx, W, (t % 5 == 0) ? 7 : -1);
      if (t % 3 == 0) begin
        do_rerun();
        stream(nx, 0, 0, W, -1);
      end
      if (t % 4 == 0) begin
        @(negedge clk);
        chk("R1", "idle between passes", valid_o, 0);
      end
    end

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 100000);
    miscompares++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule